// File: doc/BRIEF.md
# Mailbox Auto-Acknowledge and Chain Sequencer

This block sits beside an array of mailbox slots and supplies the automatic behaviour of their two-bit send registers. Bit 0 of a slot's send register raises the message interrupt toward the destinations, and bit 1 raises the acknowledge interrupt toward the slot's owner. When a slot runs in auto-acknowledge mode, the block watches the destination vector. Once every destination has cleared its own channel bit while the message is still pending, the block turns the message into an acknowledge: bit 0 clears and bit 1 sets in a single update.

When a slot runs in link mode, the block reacts to its acknowledge in a different way. The acknowledge interrupt toward the owner is gated off. Instead, the message bit of the next-numbered slot is set, so the message preloaded there goes out. An owner can therefore preload a run of slots, start the first one, and receive one acknowledge only when the last slot in the run finishes.

The slots keep their own storage and bus decode. Every cycle they hand the block their mode bits, destination vectors, current send values and any bus write aimed at a send register. In return the block tells each slot whether to load its send register and with what value, and gives each slot a gate for its owner acknowledge interrupt.

Top module: `mbx_autoack_chain`

## Requirements
- R1: Slot i at send bits [2i+1:2i], bit 0 = message, bit 1 = acknowledge. If slot i has auto-acknowledge set, its destination vector (bits [NUM_CH*i +: NUM_CH]) is all zero and its message bit is 1 at a clock edge, then during the next cycle the block asserts the load for slot i with bit 0 cleared and bit 1 set, so the slot holds 2'b10 after that cycle's edge.
- R2: While any bit of the destination vector of an auto-acknowledge slot is still set, the block makes no automatic change to that slot's send register.
- R3: With auto-acknowledge off, a destination vector of zero causes no automatic update. The slot's send register changes only through bus writes, which the block passes through unchanged: load equals the bus write strobe and the next value equals the written value.
- R4: The owner acknowledge gate of slot i is low whenever the link bit of slot i is set and i is not the highest-numbered slot. Otherwise it is high.
- R5: When the acknowledge bit of a linked slot i (i below the highest) is seen to rise at a clock edge, the block sets the message bit of slot i+1 during the next cycle and keeps that slot's acknowledge bit. Chains of several slots advance slot by slot in this way.
- R6: The link bit of the highest-numbered slot has no effect. Its acknowledge gate stays high, and no slot receives a forwarded message from it.
- R7: Forwarding along a link works the same whether the acknowledge was produced automatically or written by a core with auto-acknowledge off.
- R8: When an automatic update and a bus write target the same send register in one cycle, the automatic update is applied to the slot's current value and the bus write is discarded.
- R9: One drain event produces exactly one automatic acknowledge load. The load is not repeated in the cycle after it, even though the slot has not yet taken the new value.
- R10: After reset no load is requested for any slot, and with all link bits clear every acknowledge gate is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_mode_i | input | NUM_SLOTS | Auto-acknowledge mode bit per slot |
| link_mode_i | input | NUM_SLOTS | Link mode bit per slot |
| dest_flat_i | input | NUM_SLOTS*NUM_CH | Destination vectors, slot i at [NUM_CH*i +: NUM_CH] |
| send_flat_i | input | NUM_SLOTS*2 | Current send registers, slot i at [2i+1:2i] |
| bus_wr_i | input | NUM_SLOTS | Bus write to slot i's send register this cycle |
| bus_send_flat_i | input | NUM_SLOTS*2 | Value carried by that bus write, per slot |
| send_load_o | output | NUM_SLOTS | Slot i loads its send register at the coming edge |
| send_next_flat_o | output | NUM_SLOTS*2 | Value to load, per slot |
| ack_pass_o | output | NUM_SLOTS | Gate for the owner acknowledge interrupt, per slot |

## Verification
Directed cases drain a destination vector one bit at a time. They tell a premature acknowledge apart from one that waits for the last release, and they separate auto-acknowledge from manual mode on an identical drained vector. Chains of two and three slots are started both by automatic and by core-written acknowledges, and a link bit on the top slot checks that nothing wraps or gets gated. A collision case writes the send register in the exact cycle of the forced update. A long random run then mixes modes, sparse destination vectors and bus writes against a cycle model, which catches ordering faults between drain, rise detection and forwarding.

// File: rtl/mbx_seq_pkg.sv
package mbx_seq_pkg;
    localparam int SEND_W  = 2;
    localparam int MSG_BIT = 0;
    localparam int ACK_BIT = 1;

    typedef logic [SEND_W-1:0] send_t;

    // drain detector state for one slot
    typedef struct packed {
        logic ack_pend;
    } det_state_t;

    // merge state for one slot: forwarded message pending, and
    // last observed acknowledge bit of the upstream slot
    typedef struct packed {
        logic link_pend;
        logic up_seen;
    } mrg_state_t;
endpackage

// File: rtl/mbx_slot_detect.sv
module mbx_slot_detect
    import mbx_seq_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            auto_ack_i,
    input  logic [CH_W-1:0] dest_i,
    input  logic            msg_i,
    output logic            ack_pend_o
);
    det_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // fire once per drain; a pending request masks re-detection
        // until the slot has taken the forced value
        st_d.ack_pend = auto_ack_i && (dest_i == '0) && msg_i && !st_q.ack_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_pend_o = st_q.ack_pend;

    // R1: a request only follows a drained vector with the message up
    p_ack_after_drain_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ack_pend |-> $past((dest_i == '0) && msg_i));

    // R3: no request unless the slot was in auto-acknowledge mode
    p_ack_needs_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ack_pend |-> $past(auto_ack_i));

    // R9: a request lasts exactly one cycle
    p_ack_one_shot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ack_pend |=> !st_q.ack_pend);
endmodule

// File: rtl/mbx_send_merge.sv
module mbx_send_merge
    import mbx_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ack_pend_i,
    input  logic  up_link_i,
    input  logic  up_ack_i,
    input  send_t cur_i,
    input  logic  bus_wr_i,
    input  send_t bus_val_i,
    output logic  load_o,
    output send_t next_o
);
    mrg_state_t st_d, st_q;
    logic       link_req;
    logic       force_upd;

    always_comb begin
        st_d          = st_q;
        link_req      = up_link_i && up_ack_i && !st_q.up_seen;
        st_d.link_pend = link_req;
        st_d.up_seen  = up_ack_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // forced updates win over a bus write in the same cycle
    always_comb begin
        force_upd = ack_pend_i || st_q.link_pend;
        next_o    = bus_val_i;
        if (force_upd) begin
            next_o = cur_i;
            if (ack_pend_i) begin
                next_o[ACK_BIT] = 1'b1;
                next_o[MSG_BIT] = 1'b0;
            end
            if (st_q.link_pend) begin
                next_o[MSG_BIT] = 1'b1;
            end
        end
        load_o = force_upd || bus_wr_i;
    end

    // R5: a forwarded message follows an upstream acknowledge rise on a link
    p_link_follows_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.link_pend |-> $past(up_link_i && up_ack_i));

    // R8: an acknowledge request overrides whatever the bus writes
    p_ack_beats_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pend_i && !st_q.link_pend) |-> (load_o && next_o == 2'b10));
endmodule

// File: rtl/mbx_autoack_chain.sv
module mbx_autoack_chain
    import mbx_seq_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_CH    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SLOTS-1:0]        ack_mode_i,
    input  logic [NUM_SLOTS-1:0]        link_mode_i,
    input  logic [NUM_SLOTS*NUM_CH-1:0] dest_flat_i,
    input  logic [NUM_SLOTS*SEND_W-1:0] send_flat_i,
    input  logic [NUM_SLOTS-1:0]        bus_wr_i,
    input  logic [NUM_SLOTS*SEND_W-1:0] bus_send_flat_i,
    output logic [NUM_SLOTS-1:0]        send_load_o,
    output logic [NUM_SLOTS*SEND_W-1:0] send_next_flat_o,
    output logic [NUM_SLOTS-1:0]        ack_pass_o
);
    localparam int LAST = NUM_SLOTS - 1;

    logic [NUM_SLOTS-1:0] ack_pend;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        send_t cur;
        send_t bus_val;
        send_t nxt;
        logic  up_link;
        logic  up_ack;

        assign cur     = send_flat_i[SEND_W*i +: SEND_W];
        assign bus_val = bus_send_flat_i[SEND_W*i +: SEND_W];

        if (i == 0) begin : g_head
            assign up_link = 1'b0;
            assign up_ack  = 1'b0;
        end else begin : g_body
            assign up_link = link_mode_i[i-1];
            assign up_ack  = send_flat_i[SEND_W*(i-1) + ACK_BIT];
        end

        if (i == LAST) begin : g_top_gate
            assign ack_pass_o[i] = 1'b1;
        end else begin : g_link_gate
            assign ack_pass_o[i] = !link_mode_i[i];
        end

        mbx_slot_detect #(.CH_W(NUM_CH)) u_det (
            .clk        (clk),
            .rst_n      (rst_n),
            .auto_ack_i (ack_mode_i[i]),
            .dest_i     (dest_flat_i[NUM_CH*i +: NUM_CH]),
            .msg_i      (cur[MSG_BIT]),
            .ack_pend_o (ack_pend[i])
        );

        mbx_send_merge u_mrg (
            .clk        (clk),
            .rst_n      (rst_n),
            .ack_pend_i (ack_pend[i]),
            .up_link_i  (up_link),
            .up_ack_i   (up_ack),
            .cur_i      (cur),
            .bus_wr_i   (bus_wr_i[i]),
            .bus_val_i  (bus_val),
            .load_o     (send_load_o[i]),
            .next_o     (nxt)
        );

        assign send_next_flat_o[SEND_W*i +: SEND_W] = nxt;
    end

    // R10: no load request in the first cycle out of reset
    p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (send_load_o == '0 || bus_wr_i != '0));

    // R6: the highest slot never forwards, so slot 0 never gets a link load
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (send_load_o[0] && !bus_wr_i[0] && !ack_pend[0]) |-> 1'b0);
endmodule

// File: tb/mbx_autoack_chain_tb.sv
module mbx_autoack_chain_tb;
    localparam int N          = 4;
    localparam int CH         = 4;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [N-1:0]    am, lm, bw;
    logic [N*CH-1:0] dest;
    logic [1:0]      send_m [N];
    logic [1:0]      send_pend [N];
    logic [1:0]      bval [N];
    logic [N*2-1:0]  send_flat, bval_flat;

    logic [N-1:0]    ld, pass;
    logic [N*2-1:0]  nx_flat;

    logic m_ack [N];
    logic m_link [N];
    logic m_seen [N];
    int   ld_cnt [N];
    int   total = 0;
    int   bad = 0;
    bit   done = 0;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            send_flat[2*i +: 2] = send_m[i];
            bval_flat[2*i +: 2] = bval[i];
        end
    end

    mbx_autoack_chain #(.NUM_SLOTS(N), .NUM_CH(CH)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .ack_mode_i       (am),
        .link_mode_i      (lm),
        .dest_flat_i      (dest),
        .send_flat_i      (send_flat),
        .bus_wr_i         (bw),
        .bus_send_flat_i  (bval_flat),
        .send_load_o      (ld),
        .send_next_flat_o (nx_flat),
        .ack_pass_o       (pass)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] f_next(input logic a, input logic l,
                                          input logic [1:0] cur,
                                          input logic [1:0] b);
        logic [1:0] r;
        if (a || l) begin
            r = cur;
            if (a) begin r[1] = 1'b1; r[0] = 1'b0; end
            if (l) r[0] = 1'b1;
        end else begin
            r = b;
        end
        return r;
    endfunction

    // one cycle: inputs already set at the falling edge
    task automatic step();
        logic na [N];
        logic nl [N];
        logic ns [N];
        #1;
        for (int i = 0; i < N; i++) begin
            logic       e_ld;
            logic       e_pass;
            logic [1:0] e_nx;
            string      tg;
            e_ld   = m_ack[i] || m_link[i] || bw[i];
            e_nx   = f_next(m_ack[i], m_link[i], send_m[i], bval[i]);
            e_pass = (i == N-1) ? 1'b1 : !lm[i];
            tg     = m_ack[i] ? "R1" : (m_link[i] ? "R5" : "R3");
            chk(ld[i] == e_ld, tg, $sformatf("load slot%0d", i), ld[i], e_ld);
            if (e_ld)
                chk(nx_flat[2*i +: 2] == e_nx, tg, $sformatf("next slot%0d", i),
                    nx_flat[2*i +: 2], e_nx);
            chk(pass[i] == e_pass, "R4", $sformatf("gate slot%0d", i), pass[i], e_pass);
            if (ld[i]) ld_cnt[i]++;
            send_pend[i] = e_ld ? e_nx : send_m[i];
            na[i] = am[i] && (dest[CH*i +: CH] == '0) && send_m[i][0] && !m_ack[i];
            nl[i] = (i > 0) ? (lm[i-1] && send_m[i-1][1] && !m_seen[i-1]) : 1'b0;
            ns[i] = send_m[i][1];
        end
        for (int i = 0; i < N; i++) begin
            m_ack[i]  = na[i];
            m_link[i] = nl[i];
            m_seen[i] = ns[i];
        end
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < N; i++) send_m[i] = send_pend[i];
        bw = '0;
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic clean();
        am = '0; lm = '0; dest = '1;
        bw = '1;
        for (int i = 0; i < N; i++) bval[i] = 2'b00;
        step();
        steps(3);
    endtask

    task automatic wr(input int s, input logic [1:0] v);
        bw[s]   = 1'b1;
        bval[s] = v;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c0;
        void'($urandom(32'd20240611));
        am = '0; lm = '0; bw = '0; dest = '1;
        for (int i = 0; i < N; i++) begin
            send_m[i] = 2'b00; send_pend[i] = 2'b00; bval[i] = 2'b00;
            m_ack[i] = 1'b0; m_link[i] = 1'b0; m_seen[i] = 1'b0; ld_cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        chk(ld == '0, "R10", "load after reset", ld, 0);
        chk(pass == '1, "R10", "gates after reset", pass, 4'hf);
        @(negedge clk);

        // R2 / R1: drain one bit at a time
        clean();
        am[0] = 1'b1;
        dest[0 +: CH] = 4'b0011;
        wr(0, 2'b01);
        step();
        dest[0 +: CH] = 4'b0001;
        steps(3);
        chk(send_m[0] == 2'b01, "R2", "slot0 before last release", send_m[0], 1);
        c0 = ld_cnt[0];
        dest[0 +: CH] = 4'b0000;
        steps(2);
        chk(send_m[0] == 2'b10, "R1", "slot0 after drain", send_m[0], 2);
        steps(3);
        chk(ld_cnt[0] - c0 == 1, "R9", "loads per drain", ld_cnt[0] - c0, 1);

        // R3: manual mode ignores a drained vector
        clean();
        dest[0 +: CH] = 4'b0000;
        wr(0, 2'b01);
        step();
        c0 = ld_cnt[0];
        steps(4);
        chk(send_m[0] == 2'b01, "R3", "slot0 manual mode", send_m[0], 1);
        chk(ld_cnt[0] == c0, "R3", "loads in manual mode", ld_cnt[0] - c0, 0);

        // R4 / R7: link with a core-written acknowledge
        clean();
        lm[0] = 1'b1;
        #1;
        chk(pass[0] == 1'b0, "R4", "gate of linked slot0", pass[0], 0);
        wr(0, 2'b10);
        step();
        steps(3);
        chk(send_m[1] == 2'b01, "R7", "slot1 after manual ack", send_m[1], 1);
        chk(send_m[0] == 2'b10, "R7", "slot0 keeps ack", send_m[0], 2);

        // R5: three-slot chain driven by auto-acknowledge
        clean();
        am[1:0] = 2'b11; lm[1:0] = 2'b11;
        dest[0 +: CH] = '0; dest[CH +: CH] = '0; dest[2*CH +: CH] = 4'b0100;
        wr(0, 2'b01);
        step();
        steps(10);
        chk(send_m[0] == 2'b10, "R5", "chain slot0", send_m[0], 2);
        chk(send_m[1] == 2'b10, "R5", "chain slot1", send_m[1], 2);
        chk(send_m[2] == 2'b01, "R5", "chain slot2", send_m[2], 1);

        // R6: link bit on the top slot has no effect
        clean();
        lm[N-1] = 1'b1;
        #1;
        chk(pass[N-1] == 1'b1, "R6", "top slot gate", pass[N-1], 1);
        wr(N-1, 2'b10);
        step();
        steps(4);
        chk(send_m[0] == 2'b00, "R6", "slot0 after top ack", send_m[0], 0);

        // R8: bus write in the forced-update cycle is dropped
        clean();
        am[0] = 1'b1;
        dest[0 +: CH] = '0;
        wr(0, 2'b01);
        step();
        step();
        wr(0, 2'b00);
        step();
        chk(send_m[0] == 2'b10, "R8", "slot0 after collision", send_m[0], 2);

        // random mix against the cycle model
        clean();
        for (int cyc = 0; cyc < 3000; cyc++) begin
            if (cyc % 40 == 0) begin
                am = N'($urandom);
                lm = N'($urandom);
            end
            for (int i = 0; i < N; i++) begin
                dest[CH*i +: CH] = ($urandom % 3 == 0) ? '0 : CH'($urandom);
                if ($urandom % 6 == 0) begin
                    bw[i]   = 1'b1;
                    bval[i] = 2'($urandom % 3);
                end
            end
            step();
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule